// File: doc/BRIEF.md
# Transfer Controller Activation Arbiter

This block sits between a set of peripheral interrupt sources and a data transfer engine. Each source owns an event flag, set by a one-cycle pulse from its peripheral, and a route bit. A set route bit sends the flagged request to the transfer engine. A clear route bit sends it to the CPU as a level interrupt. Software can also start a transfer on its own: it writes a vector, which arms a software trigger bit.

Only one transfer is in flight at a time. When the engine is idle and requests are waiting, the block picks one by fixed priority. It then issues a one-cycle start pulse together with the vector of the winning request. The engine answers with a done pulse that carries three status bits: another chained link follows, the transfer count ran out, and interrupt after every transfer was selected. After the final link the block cleans up. If neither status bit is set, a hardware source has its flag cleared and keeps its route bit. Otherwise the route bit is cleared and the flag stays set, so the request falls through to the CPU. A software trigger follows the mirrored rule.

Top module: `xfer_activation_arbiter`

## Requirements
- R1: `cpu_irq[i]` is high exactly when `src_flag[i]` is 1 and `route_en[i]` is 0. A routed source never raises a CPU interrupt, whatever its flag state.
- R2: When idle, the pending request with the lowest source index wins. The software trigger ranks below every hardware source. A hardware winner drives `xfer_vec` with its index, zero-extended. A software winner drives `xfer_vec` with the stored software vector.
- R3: `xfer_start` is a one-cycle pulse issued only while no transfer is outstanding. The next pulse comes no earlier than the cycle after the final done has been taken. A done pulse seen while idle has no effect.
- R4: A hardware transfer that ends with `xfer_cnt_end`=0 and `xfer_irq_sel`=0 clears that source's flag, keeps its route bit at 1 and raises no CPU interrupt.
- R5: A hardware transfer that ends with `xfer_cnt_end`=1 or `xfer_irq_sel`=1 clears that source's route bit. Its flag stays set, so `cpu_irq` for that source goes high.
- R6: A pulse on `sw_vec_wr` while `sw_en` is 0 stores `sw_vec_wdata` and sets `sw_en`. The same pulse while `sw_en` is 1 is ignored and leaves the stored vector unchanged.
- R7: A software transfer that ends with both status bits 0 clears `sw_en`.
- R8: A software transfer that ends with either status bit 1 keeps `sw_en` at 1 and sets `sw_irq`. While `sw_irq` is 1 the software trigger does not start another transfer. `sw_cancel` clears both `sw_en` and `sw_irq`.
- R9: A done pulse with `xfer_more`=1 finishes one link of a chain. It changes no flag, route bit or software bit, and the transfer stays outstanding.
- R10: A `src_evt` pulse sets its flag on the next edge. This happens even when a completion clear or a `src_flag_clr` hits the same flag in the same cycle.
- R11: A `en_wr` pulse loads all route bits from `en_wdata`. If a completion clears a route bit in the same cycle, that bit ends at 0.
- R12: After reset all flags, route bits, `sw_en`, `sw_irq` and `xfer_start` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_evt | input | N_SRC | One-cycle event pulses that set source flags |
| src_flag_clr | input | N_SRC | CPU-side flag clear pulses |
| en_wr | input | 1 | Load route bits |
| en_wdata | input | N_SRC | New route bit values |
| sw_vec_wr | input | 1 | Software vector write, arms the software trigger |
| sw_vec_wdata | input | VEC_W | Software vector value |
| sw_cancel | input | 1 | Clears software trigger and its interrupt |
| xfer_start | output | 1 | One-cycle transfer start pulse |
| xfer_vec | output | VEC_W | Vector of the started transfer |
| xfer_done | input | 1 | Engine done pulse |
| xfer_more | input | 1 | Further chained links follow this done |
| xfer_cnt_end | input | 1 | Transfer count ran out |
| xfer_irq_sel | input | 1 | Interrupt after every transfer selected |
| route_en | output | N_SRC | Current route bits (1 = transfer engine) |
| src_flag | output | N_SRC | Current source flags |
| sw_en | output | 1 | Software trigger bit |
| cpu_irq | output | N_SRC | Level interrupts to the CPU |
| sw_irq | output | 1 | Level interrupt after a software transfer |

## Verification
The bench builds the block with N_SRC=4 and VEC_W=6. Four sources are enough to make simultaneous events on non-adjacent sources exercise the priority scan from both ends. A 6-bit vector lets software vectors differ clearly from every hardware index. The bench also acts as the transfer engine, with a short fixed latency and a selectable number of chain links. That latency keeps events, flag clears and route writes landing in the same cycle as a completion within a short run.

// File: rtl/xfer_activation_arbiter.sv
module xfer_activation_arbiter #(
  parameter int N_SRC = 8,
  parameter int VEC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] src_evt,
  input  logic [N_SRC-1:0] src_flag_clr,
  input  logic             en_wr,
  input  logic [N_SRC-1:0] en_wdata,
  input  logic             sw_vec_wr,
  input  logic [VEC_W-1:0] sw_vec_wdata,
  input  logic             sw_cancel,
  output logic             xfer_start,
  output logic [VEC_W-1:0] xfer_vec,
  input  logic             xfer_done,
  input  logic             xfer_more,
  input  logic             xfer_cnt_end,
  input  logic             xfer_irq_sel,
  output logic [N_SRC-1:0] route_en,
  output logic [N_SRC-1:0] src_flag,
  output logic             sw_en,
  output logic [N_SRC-1:0] cpu_irq,
  output logic             sw_irq
);
  localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1;

  logic             busy, cur_sw, start_q, swirq_q;
  logic [IDX_W-1:0] cur_idx, win_idx;
  logic [VEC_W-1:0] vec_q, swvec_q;
  logic [N_SRC-1:0] en_q, flag_q, hw_req, cur_mask, flag_kill, en_kill;

  assign hw_req   = flag_q & en_q;
  wire   sw_req   = sw_en & ~swirq_q;
  wire   any_req  = (|hw_req) | sw_req;
  wire   finish   = busy & xfer_done & ~xfer_more;
  wire   hard_end = xfer_cnt_end | xfer_irq_sel;
  wire   hw_fin   = finish & ~cur_sw;
  wire   sw_fin   = finish & cur_sw;

  always_comb begin
    win_idx = '0;
    for (int i = N_SRC - 1; i >= 0; i--)
      if (hw_req[i]) win_idx = IDX_W'(i);
  end

  assign cur_mask  = N_SRC'(1) << cur_idx;
  assign flag_kill = (hw_fin & ~hard_end) ? cur_mask : '0;
  assign en_kill   = (hw_fin &  hard_end) ? cur_mask : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      cur_sw  <= 1'b0;
      cur_idx <= '0;
      start_q <= 1'b0;
      vec_q   <= '0;
    end else begin
      start_q <= 1'b0;
      if (finish) begin
        busy <= 1'b0;
      end else if (!busy && any_req) begin
        busy    <= 1'b1;
        start_q <= 1'b1;
        cur_sw  <= ~(|hw_req);
        cur_idx <= win_idx;
        vec_q   <= (|hw_req) ? VEC_W'(win_idx) : swvec_q;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= '0;
      en_q   <= '0;
    end else begin
      flag_q <= (flag_q & ~flag_kill & ~src_flag_clr) | src_evt;
      en_q   <= (en_wr ? en_wdata : en_q) & ~en_kill;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sw_en   <= 1'b0;
      swirq_q <= 1'b0;
      swvec_q <= '0;
    end else begin
      if (sw_cancel) begin
        sw_en   <= 1'b0;
        swirq_q <= 1'b0;
      end else if (sw_fin) begin
        sw_en   <= hard_end;
        swirq_q <= hard_end;
      end else if (sw_vec_wr && !sw_en) begin
        sw_en   <= 1'b1;
        swvec_q <= sw_vec_wdata;
      end
    end
  end

  assign xfer_start = start_q;
  assign xfer_vec   = vec_q;
  assign route_en   = en_q;
  assign src_flag   = flag_q;
  assign cpu_irq    = flag_q & ~en_q;
  assign sw_irq     = swirq_q;

  a_r3_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_start |=> !xfer_start);
  a_r4_flag_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_fin && !hard_end && !src_evt[cur_idx]) |=> !src_flag[$past(cur_idx)]);
  a_r5_route_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_fin && hard_end) |=> !route_en[$past(cur_idx)]);
  a_r6_vec_held: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_en && sw_vec_wr) |=> $stable(swvec_q));
  a_r7_sw_done: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_fin && !hard_end) |=> !sw_en);
  a_r8_sw_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_fin && hard_end && !sw_cancel) |=> (sw_irq && sw_en));
  a_r9_chain_link: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && xfer_done && xfer_more) |=> (busy && $stable(sw_en)));
  a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (|src_evt) |=> ((src_flag & $past(src_evt)) == $past(src_evt)));
endmodule

// File: tb/test_xfer_activation_arbiter.sv
module test_xfer_activation_arbiter;
  localparam int N = 4;
  localparam int VW = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] src_evt = '0, src_flag_clr = '0, en_wdata = '0;
  logic en_wr = 1'b0, sw_vec_wr = 1'b0, sw_cancel = 1'b0;
  logic [VW-1:0] sw_vec_wdata = '0;
  logic xfer_done = 1'b0, xfer_more = 1'b0, xfer_cnt_end = 1'b0, xfer_irq_sel = 1'b0;
  logic xfer_start, sw_en, sw_irq;
  logic [VW-1:0] xfer_vec;
  logic [N-1:0] route_en, src_flag, cpu_irq;

  int tests = 0, fails = 0, cyc = 0;
  int eng_links = 0, eng_cnt = 0, eng_left = 0;
  logic eng_end = 1'b0, eng_sel = 1'b0;

  always #5 clk = ~clk;

  xfer_activation_arbiter #(.N_SRC(N), .VEC_W(VW)) i_xfer_activation_arbiter (
    .clk(clk), .rst_n(rst_n), .src_evt(src_evt), .src_flag_clr(src_flag_clr),
    .en_wr(en_wr), .en_wdata(en_wdata), .sw_vec_wr(sw_vec_wr), .sw_vec_wdata(sw_vec_wdata),
    .sw_cancel(sw_cancel), .xfer_start(xfer_start), .xfer_vec(xfer_vec),
    .xfer_done(xfer_done), .xfer_more(xfer_more), .xfer_cnt_end(xfer_cnt_end),
    .xfer_irq_sel(xfer_irq_sel), .route_en(route_en), .src_flag(src_flag), .sw_en(sw_en),
    .cpu_irq(cpu_irq), .sw_irq(sw_irq));

  // behavioural reference
  bit m_busy = 0, m_cur_sw = 0, m_start = 0, m_swen = 0, m_swirq = 0;
  int m_cur = 0, m_vec = 0, m_swvec = 0;
  bit [N-1:0] m_flag = '0, m_en = '0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_cur_sw = 0; m_start = 0; m_swen = 0; m_swirq = 0;
      m_cur = 0; m_vec = 0; m_swvec = 0; m_flag = '0; m_en = '0;
    end else begin
      bit [N-1:0] nf, ne;
      bit fin, hard, nsw, nirq, nbusy, nstart;
      int nswvec, nvec, ncur, pick;
      bit ncsw;
      fin = m_busy && xfer_done && !xfer_more;
      hard = xfer_cnt_end || xfer_irq_sel;
      nf = m_flag; ne = en_wr ? en_wdata : m_en;
      nsw = m_swen; nirq = m_swirq; nswvec = m_swvec;
      nbusy = m_busy; nstart = 0; nvec = m_vec; ncur = m_cur; ncsw = m_cur_sw;
      if (fin && !m_cur_sw) begin
        if (hard) ne[m_cur] = 1'b0;
        else nf[m_cur] = 1'b0;
      end
      for (int i = 0; i < N; i++) begin
        if (src_flag_clr[i]) nf[i] = 1'b0;
        if (src_evt[i]) nf[i] = 1'b1;
      end
      if (sw_cancel) begin nsw = 0; nirq = 0; end
      else if (fin && m_cur_sw) begin nsw = hard; nirq = hard; end
      else if (sw_vec_wr && !m_swen) begin nsw = 1; nswvec = sw_vec_wdata; end
      if (fin) nbusy = 0;
      else if (!m_busy) begin
        pick = -1;
        for (int i = N - 1; i >= 0; i--) if (m_flag[i] && m_en[i]) pick = i;
        if (pick >= 0) begin
          nbusy = 1; nstart = 1; nvec = pick; ncur = pick; ncsw = 0;
        end else if (m_swen && !m_swirq) begin
          nbusy = 1; nstart = 1; nvec = m_swvec; ncsw = 1;
        end
      end
      m_flag = nf; m_en = ne; m_swen = nsw; m_swirq = nirq; m_swvec = nswvec;
      m_busy = nbusy; m_start = nstart; m_vec = nvec; m_cur = ncur; m_cur_sw = ncsw;
    end
  end

  task automatic check(string tag, int act, int exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at cycle %0d: actual %0h expected %0h", tag, cyc, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst_n) check("R12 reset", {route_en, src_flag, sw_en, sw_irq, xfer_start}, 0);
    check("R2/R3/R9 start", xfer_start, m_start);
    if (m_start) check("R2/R6 vector", xfer_vec, m_vec);
    check("R1/R5 cpu_irq", cpu_irq, m_flag & ~m_en);
    check("R5/R11 route", route_en, m_en);
    check("R4/R10 flag", src_flag, m_flag);
    check("R6/R7 sw_en", sw_en, m_swen);
    check("R8 sw_irq", sw_irq, m_swirq);
  end

  // transfer engine stand-in
  always @(negedge clk) begin
    xfer_done = 0; xfer_more = 0;
    if (!rst_n) begin eng_cnt = 0; eng_left = 0; end
    else if (xfer_start) begin eng_cnt = 2; eng_left = eng_links; end
    else if (eng_cnt > 0) begin
      eng_cnt--;
      if (eng_cnt == 0) begin
        xfer_done = 1; xfer_cnt_end = eng_end; xfer_irq_sel = eng_sel;
        if (eng_left > 0) begin xfer_more = 1; eng_left--; eng_cnt = 2; end
      end
    end
  end

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected below 20000", cyc);
      summary();
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    tick(3);
    rst_n = 1;
    tick(1);
    // R1: unrouted source goes to CPU
    src_evt = 4'b0100; tick(1); src_evt = '0; tick(2);
    src_flag_clr = 4'b0100; tick(1); src_flag_clr = '0; tick(1);
    // R2 R4: route all, two events together, lowest index first
    en_wr = 1; en_wdata = 4'b1111; tick(1); en_wr = 0;
    src_evt = 4'b1010; tick(1); src_evt = '0; tick(16);
    // R2 R6: software below hardware
    sw_vec_wr = 1; sw_vec_wdata = 6'h2A; src_evt = 4'b0001; tick(1);
    sw_vec_wr = 0; src_evt = '0; tick(16);
    // R5: count exhausted
    eng_end = 1; src_evt = 4'b0100; tick(1); src_evt = '0; tick(8);
    src_flag_clr = 4'b0100; tick(1); src_flag_clr = '0; eng_end = 0;
    // R5: select bit
    en_wr = 1; en_wdata = 4'b1111; tick(1); en_wr = 0;
    eng_sel = 1; src_evt = 4'b1000; tick(1); src_evt = '0; tick(8);
    src_flag_clr = 4'b1000; tick(1); src_flag_clr = '0;
    // R8 R6: software final, retrigger blocked, rewrite ignored
    sw_vec_wr = 1; sw_vec_wdata = 6'h15; tick(1); sw_vec_wr = 0; tick(10);
    sw_vec_wr = 1; sw_vec_wdata = 6'h33; tick(1); sw_vec_wr = 0; tick(4);
    sw_cancel = 1; tick(1); sw_cancel = 0; eng_sel = 0; tick(2);
    sw_vec_wr = 1; sw_vec_wdata = 6'h07; tick(1); sw_vec_wr = 0; tick(10);
    // R9: chain of three links
    en_wr = 1; en_wdata = 4'b1111; tick(1); en_wr = 0;
    eng_links = 2; src_evt = 4'b0010; tick(1); src_evt = '0; tick(16); eng_links = 0;
    // R3: stray done while idle
    tick(2); xfer_done = 1; tick(1); tick(2);
    // R10 R11: collisions of events, clears and route writes with completions
    for (int k = 0; k < 80; k++) begin
      src_evt = (k % 3 == 0) ? 4'b0001 : ((k % 7 == 0) ? 4'b0100 : 4'b0000);
      src_flag_clr = (k % 5 == 0) ? 4'b0001 : 4'b0000;
      en_wr = (k % 4 == 1); en_wdata = 4'b1111;
      eng_end = (k % 2 == 0);
      tick(1);
    end
    src_evt = '0; src_flag_clr = '0; en_wr = 0; eng_end = 0;
    tick(10);
    summary();
  end
endmodule